// File: doc/BRIEF.md
# Two-Level Nanoprogrammed Control Sequencer

This block is a control unit that keeps its program in two memories. The control memory holds many narrow microwords. Each microword carries an index and a small register number. The nano-memory holds a few wide control words, and many microwords can point at the same one. Before a run, software-side logic fills both memories through their write ports. The sequencer then walks the control memory from address 0 up to a programmable last address. For each microword it reads the control memory, then reads the nano-memory, then presents the resulting wide control word for one clock.

A nano-word may leave its register field at zero. In that case the register number from the microword is placed into that field of the output. This lets one nano-word serve several microwords that differ only in the register they select. The two reads are never overlapped, so each microstep costs three clocks.

The sequencer has five states. IDLE is entered on reset. IDLE and DONE go to UFETCH on start. UFETCH always goes to NFETCH, and NFETCH always goes to EXEC. EXEC goes back to UFETCH when the current address differs from the last address. EXEC goes to DONE when the current address equals the last address. DONE stays put until the next start.

Top module: `nano_ctrl_store`

## Requirements
- R1: While reset is held and after its release, ctrl_valid, done and ctrl_word are all zero until a start is accepted.
- R2: A start accepted while idle or done begins a run. ctrl_valid is first high exactly three clocks after the start edge. It is high for one clock per microstep, and consecutive high clocks are exactly three clocks apart.
- R3: ctrl_word is all zeros in every clock in which ctrl_valid is low.
- R4: A microword is laid out as {index, reg}. Bits [3:0] hold the register number and the bits above hold the nano-memory index. In the valid clock of a step, ctrl_word equals the nano-word selected by that index, except for bits [3:0]. Microwords with equal indices yield the same word.
- R5: When bits [3:0] of the selected nano-word are zero, bits [3:0] of ctrl_word equal the microword's register number. Otherwise they equal the nano-word's own bits [3:0].
- R6: Steps run at control addresses 0, 1, ..., end_addr in order, giving end_addr+1 valid clocks. done rises in the clock after the last valid clock and stays high until the next start, including when end_addr is 0.
- R7: Writes to either memory are performed only while the sequencer is idle or done. A write presented during a run leaves the memory unchanged.
- R8: A start pulse during a run is ignored. A start while done restarts from address 0 and clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run from control address 0 |
| end_addr | input | CM_AW | Last control address of the run |
| cm_we | input | 1 | Control-memory write enable |
| cm_waddr | input | CM_AW | Control-memory write address |
| cm_wdata | input | UW_W | Microword to write, {index, reg} |
| nm_we | input | 1 | Nano-memory write enable |
| nm_waddr | input | NM_AW | Nano-memory write address |
| nm_wdata | input | NW | Nano-word to write |
| ctrl_word | output | NW | Control word, valid with ctrl_valid, zero otherwise |
| ctrl_valid | output | 1 | High in the execute clock of each step |
| done | output | 1 | Run finished, held until next start |

## Verification
Suppose the sequencer is in the wrong state or the address counter is off. The valid pulse then comes in the wrong clock, a pulse is missing or extra, or ctrl_word carries another entry's contents. Each of these shows up no later than the next expected valid clock, three clocks at most. A wrong end decision moves the rise of done or changes the pulse count, so the fault appears at the end of the run. A faulty override or a stray write shows up as a single wrong field in the first step that reads the affected entry.

// File: rtl/nano_pkg.sv
package nano_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UFETCH,
        ST_NFETCH,
        ST_EXEC,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/nano_store.sv
module nano_store #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 100,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nano_seq_fsm.sv
module nano_seq_fsm
    import nano_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] end_addr,
    output logic [AW-1:0] upc,
    output logic          load_ok,
    output logic          uir_load,
    output logic          nir_load,
    output logic          exec_cycle,
    output logic          done
);
    localparam logic [AW-1:0] ONE = AW'(1);

    seq_state_e state, state_nx;
    logic       last_step;

    assign last_step = (upc == end_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_UFETCH;
            ST_UFETCH: state_nx = ST_NFETCH;
            ST_NFETCH: state_nx = ST_EXEC;
            ST_EXEC:   state_nx = last_step ? ST_DONE : ST_UFETCH;
            ST_DONE:   if (start) state_nx = ST_UFETCH;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc <= '0;
        end else if (load_ok && start) begin
            upc <= '0;
        end else if (exec_cycle && !last_step) begin
            upc <= upc + ONE;
        end
    end

    always_comb begin
        load_ok    = (state == ST_IDLE) || (state == ST_DONE);
        uir_load   = (state == ST_UFETCH);
        nir_load   = (state == ST_NFETCH);
        exec_cycle = (state == ST_EXEC);
        done       = (state == ST_DONE);
    end
endmodule

// File: rtl/nano_reg_merge.sv
module nano_reg_merge #(
    parameter int NW    = 100,
    parameter int REG_W = 4
) (
    input  logic [NW-1:0]    nano_word,
    input  logic [REG_W-1:0] micro_reg,
    output logic [NW-1:0]    merged
);
    logic field_empty;

    assign field_empty = (nano_word[REG_W-1:0] == '0);
    assign merged = {nano_word[NW-1:REG_W],
                     field_empty ? micro_reg : nano_word[REG_W-1:0]};
endmodule

// File: rtl/nano_ctrl_store.sv
module nano_ctrl_store #(
    parameter int CM_DEPTH = 4096,
    parameter int NM_DEPTH = 128,
    parameter int NW       = 100,
    parameter int REG_W    = 4,
    localparam int CM_AW   = $clog2(CM_DEPTH),
    localparam int NM_AW   = $clog2(NM_DEPTH),
    localparam int UW_W    = NM_AW + REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CM_AW-1:0] end_addr,
    input  logic             cm_we,
    input  logic [CM_AW-1:0] cm_waddr,
    input  logic [UW_W-1:0]  cm_wdata,
    input  logic             nm_we,
    input  logic [NM_AW-1:0] nm_waddr,
    input  logic [NW-1:0]    nm_wdata,
    output logic [NW-1:0]    ctrl_word,
    output logic             ctrl_valid,
    output logic             done
);
    logic [CM_AW-1:0] upc;
    logic             load_ok, uir_load, nir_load, exec_cycle;
    logic [UW_W-1:0]  cm_rdata, uir;
    logic [NW-1:0]    nm_rdata, merged, nir;

    nano_seq_fsm #(.AW(CM_AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .end_addr   (end_addr),
        .upc        (upc),
        .load_ok    (load_ok),
        .uir_load   (uir_load),
        .nir_load   (nir_load),
        .exec_cycle (exec_cycle),
        .done       (done)
    );

    nano_store #(.DEPTH(CM_DEPTH), .WIDTH(UW_W)) u_cmem (
        .clk   (clk),
        .we    (cm_we && load_ok),
        .waddr (cm_waddr),
        .wdata (cm_wdata),
        .raddr (upc),
        .rdata (cm_rdata)
    );

    nano_store #(.DEPTH(NM_DEPTH), .WIDTH(NW)) u_nmem (
        .clk   (clk),
        .we    (nm_we && load_ok),
        .waddr (nm_waddr),
        .wdata (nm_wdata),
        .raddr (uir[UW_W-1:REG_W]),
        .rdata (nm_rdata)
    );

    nano_reg_merge #(.NW(NW), .REG_W(REG_W)) u_merge (
        .nano_word (nm_rdata),
        .micro_reg (uir[REG_W-1:0]),
        .merged    (merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uir <= '0;
            nir <= '0;
        end else begin
            if (uir_load) uir <= cm_rdata;
            if (nir_load) nir <= merged;
        end
    end

    assign ctrl_valid = exec_cycle;
    assign ctrl_word  = exec_cycle ? nir : '0;
endmodule

// File: rtl/nano_ctrl_store_chk.sv
module nano_ctrl_store_chk #(
    parameter int NW = 100
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [NW-1:0] ctrl_word,
    input logic          ctrl_valid,
    input logic          done
);
    p_quiet_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_valid |-> (ctrl_word == '0));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |=> !ctrl_valid);

    p_pulse_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |=> !ctrl_valid ##1 !ctrl_valid);

    p_done_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ctrl_valid);

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_done_after_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(ctrl_valid));
endmodule

bind nano_ctrl_store nano_ctrl_store_chk #(.NW(NW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ctrl_word  (ctrl_word),
    .ctrl_valid (ctrl_valid),
    .done       (done)
);

// File: tb/nano_ctrl_store_test.sv
module nano_ctrl_store_test;
    localparam int CMD = 4096;
    localparam int NMD = 128;
    localparam int NW  = 100;
    localparam int CAW = 12;
    localparam int NAW = 7;
    localparam int UW  = 11;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [CAW-1:0] end_addr = '0;
    logic           cm_we = 1'b0;
    logic [CAW-1:0] cm_waddr = '0;
    logic [UW-1:0]  cm_wdata = '0;
    logic           nm_we = 1'b0;
    logic [NAW-1:0] nm_waddr = '0;
    logic [NW-1:0]  nm_wdata = '0;
    logic [NW-1:0]  ctrl_word;
    logic           ctrl_valid;
    logic           done;

    int errors = 0;
    int checks = 0;
    int valid_seen = 0;

    always #2 clk = ~clk;

    nano_ctrl_store uut (
        .clk(clk), .rst_n(rst_n), .start(start), .end_addr(end_addr),
        .cm_we(cm_we), .cm_waddr(cm_waddr), .cm_wdata(cm_wdata),
        .nm_we(nm_we), .nm_waddr(nm_waddr), .nm_wdata(nm_wdata),
        .ctrl_word(ctrl_word), .ctrl_valid(ctrl_valid), .done(done)
    );

    // behavioural reference: memories plus a phase counter
    logic [UW-1:0] cm_ref [CMD];
    logic [NW-1:0] nm_ref [NMD];
    int m_phase = 0;   // 0 stopped, 1 control read, 2 nano read, 3 output
    int m_addr = 0;
    bit m_done = 0;
    bit m_checking = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_addr = 0; m_done = 0;
        end else if (m_phase == 0) begin
            if (cm_we) cm_ref[cm_waddr] = cm_wdata;
            if (nm_we) nm_ref[nm_waddr] = nm_wdata;
            if (start) begin m_phase = 1; m_addr = 0; m_done = 0; end
        end else if (m_phase == 3) begin
            if (m_addr == int'(end_addr)) begin m_phase = 0; m_done = 1; end
            else begin m_phase = 1; m_addr = m_addr + 1; end
        end else begin
            m_phase = m_phase + 1;
        end
    end

    function automatic logic [NW-1:0] ref_word(int a);
        logic [UW-1:0] u;
        logic [NW-1:0] n;
        u = cm_ref[a];
        n = nm_ref[u[UW-1:4]];
        if (n[3:0] == 4'h0) n[3:0] = u[3:0];
        return n;
    endfunction

    task automatic chk(bit ok, string tag, logic [NW-1:0] act, logic [NW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && m_checking) begin
            logic [NW-1:0] ew;
            bit ev;
            ev = (m_phase == 3);
            ew = ev ? ref_word(m_addr) : '0;
            if (ctrl_valid) valid_seen++;
            chk(ctrl_valid == ev, "R2 valid timing", NW'(ctrl_valid), NW'(ev));
            chk(done == m_done, "R6 done flag", NW'(done), NW'(m_done));
            if (!ev) chk(ctrl_word == '0, "R3 idle word", ctrl_word, '0);
            else begin
                chk(ctrl_word[NW-1:4] == ew[NW-1:4], "R4 word body",
                    ctrl_word, ew);
                chk(ctrl_word[3:0] == ew[3:0], "R5 reg field",
                    ctrl_word, ew);
            end
        end
    end

    task automatic load_all();
        for (int i = 0; i < CMD; i++) begin
            @(negedge clk);
            cm_we = 1; cm_waddr = CAW'(i); cm_wdata = UW'($urandom);
        end
        for (int i = 0; i < NMD; i++) begin
            logic [127:0] r;
            @(negedge clk);
            r = {$urandom, $urandom, $urandom, $urandom};
            if (i % 2 == 0) r[3:0] = 4'h0;
            cm_we = 0; nm_we = 1; nm_waddr = NAW'(i); nm_wdata = r[NW-1:0];
        end
        @(negedge clk);
        nm_we = 0;
    endtask

    task automatic run(int last, bit disturb);
        @(negedge clk);
        end_addr = CAW'(last); start = 1; valid_seen = 0;
        forever begin
            @(negedge clk);
            start = 0; cm_we = 0; nm_we = 0;
            if (m_done) break;
            if (disturb) begin
                // R7 writes and R8 start pulses during the run
                cm_we = 1; cm_waddr = CAW'($urandom); cm_wdata = UW'($urandom);
                nm_we = 1; nm_waddr = NAW'($urandom);
                nm_wdata = {$urandom, $urandom, $urandom, $urandom};
                start = ($urandom % 3 == 0);
            end
        end
        chk(valid_seen == last + 1, "R6 step count", NW'(valid_seen), NW'(last + 1));
        repeat (4) @(negedge clk);
        chk(done == 1'b1, "R6 done held", NW'(done), NW'(1));
    endtask

    task automatic main_flow();
        repeat (3) @(negedge clk);
        chk(!ctrl_valid && !done && ctrl_word == '0, "R1 in reset",
            {ctrl_word[NW-1:2], ctrl_valid, done}, '0);
        rst_n = 1;
        @(negedge clk);
        chk(!ctrl_valid && !done && ctrl_word == '0, "R1 after reset",
            {ctrl_word[NW-1:2], ctrl_valid, done}, '0);
        m_checking = 1;
        load_all();
        run(5, 0);
        run(0, 0);            // R6 single step
        run(60, 1);           // R7, R8 disturbance
        // R7 write in done state takes effect in next run
        @(negedge clk);
        cm_we = 1; cm_waddr = 0; cm_wdata = {NAW'(3), 4'h9};
        nm_we = 1; nm_waddr = 3; nm_wdata = '0;
        @(negedge clk);
        cm_we = 0; nm_we = 0;
        run(2, 0);            // R5 override onto zero word
        run(CMD - 1, 0);      // R6 full wrap range
    endtask

    initial begin
        fork
            main_flow();
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL R6 watchdog actual=hung expected=finished");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule